// File: doc/BRIEF.md
# Twenty-One Hand Player State Machine

This block plays a single hand of a twenty-one style card game from the player's side. It requests cards one at a time, accepts each card through a strobe handshake, and keeps a running score. A card worth 11 is counted at that value while the score allows it. It is quietly re-valued to 1 when the hand would otherwise go over the limit. The hand ends in one of two outcomes: standing, when the score lands between 17 and 21, or bust, when it passes 21 with no high-valued card left to soften.

The surrounding logic deals by watching the request flag. It places a card value on the card input and raises the strobe, then lowers the strobe once the request flag has dropped. A synchronous new-game input restarts the hand at any time. After an outcome is reached, the block ignores all card traffic until the next new game. All state is held in plainly binary-coded registers, and the score output is driven straight from the internal score register.

Top module: `hand21_player`

## Requirements
- R1: While `new_game` is high at a rising clock edge, the block restarts. After that edge, `score` is 0 and `want_card`, `hold_flag` and `bust_flag` are all 0, whatever the block was doing before.
- R2: The first cycle after a restart is a single start cycle with `want_card` low. From the following cycle on, `want_card` is high.
- R3: While the block is requesting a card, it accepts one only on a low-to-high change of `card_strobe`. A strobe that is already high when the request begins, or that stays high, is not taken as a card, and `want_card` stays high.
- R4: An accepted card's value on `card_value` (an unsigned binary number from 2 to 11) is added to `score` exactly once, at the edge where the strobe rise is seen. The score does not change again while the strobe stays high.
- R5: After a card is accepted, `want_card` is low. The score is not evaluated until `card_strobe` has been seen low, so no flag rises while the strobe stays high.
- R6: If the updated score is 16 or less, the block requests another card. If it is 17 or more, the block goes on to the over-limit test.
- R7: In the over-limit test, a score of 21 or less takes priority over any softening. The block stands with `hold_flag` high, and `score` shows a value from 17 to 21. For example, the cards 11 then 6 stand at 17.
- R8: Each card of value 11 (binary 1011) adds one to an internal count of cards still valued high. In the over-limit test, when the score exceeds 21 and that count is non-zero, 10 is subtracted from the score, the count drops by one, and the score is tested again from the 17 check. Each such card is softened at most once, however many are held.
- R9: When the score exceeds 21 and no high-valued card remains, the block goes bust with `bust_flag` high, and `score` shows the final total, which is above 21.
- R10: Standing and bust are terminal. Further strobes and card values change neither the flags nor `score` until `new_game` is asserted.
- R11: At most one of `want_card`, `hold_flag` and `bust_flag` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| new_game | input | 1 | Synchronous active-high restart of the hand |
| card_strobe | input | 1 | Card-present strobe; its rising change marks a new card |
| card_value | input | 4 | Unsigned value of the offered card, 2 to 11 |
| want_card | output | 1 | High while the block is requesting a card |
| hold_flag | output | 1 | High once the hand stands |
| bust_flag | output | 1 | High once the hand is bust |
| score | output | 5 | Current running score of the hand |

## Verification
On every cycle, the assertions check that the score is stable whenever no card is being added or softened. They also check that each softening removes exactly 10 and one counted high card, that the single start cycle leads straight into a request, and that a request or an accepted card waits on the strobe. Further per-cycle checks cover the terminal outcomes staying put, the flags being mutually exclusive, and the stand and bust scores lying on the correct side of 21. Only the bench's scenarios can show that whole hands reach the correct outcome and final score across many card sequences. These include several high cards in one hand, the 16/17 and 21/22 boundaries, and the largest reachable total. The scenarios also show that a strobe held through a restart is not mistaken for a card.

// File: rtl/hand21_pkg.sv
package hand21_pkg;

    localparam int CARD_BITS    = 4;
    localparam int TOTAL_BITS   = 5;
    localparam int ACE_CNT_BITS = 3;
    localparam int ACE_CARD     = 11;
    localparam int HOLD_FLOOR   = 17;
    localparam int BUST_CEIL    = 21;
    localparam int ACE_DROP     = 10;

    typedef enum logic [2:0] {
        PS_START    = 3'd0,
        PS_ASK      = 3'd1,
        PS_TAKE     = 3'd2,
        PS_CHK_LOW  = 3'd3,
        PS_CHK_HIGH = 3'd4,
        PS_HOLD     = 3'd5,
        PS_BUST     = 3'd6
    } play_state_e;

    typedef enum logic [1:0] {
        ACC_KEEP   = 2'd0,
        ACC_CLEAR  = 2'd1,
        ACC_ADD    = 2'd2,
        ACC_SOFTEN = 2'd3
    } acc_op_e;

    typedef struct packed {
        logic want;
        logic hold;
        logic bust;
    } play_flags_t;

    typedef struct packed {
        logic reach_hold;
        logic within_ceil;
        logic ace_left;
    } acc_status_t;

    function automatic play_flags_t flags_of_state(input play_state_e s);
        play_flags_t f;
        f.want = (s == PS_ASK);
        f.hold = (s == PS_HOLD);
        f.bust = (s == PS_BUST);
        return f;
    endfunction

endpackage

// File: rtl/hand21_edge.sv
module hand21_edge (
    input  logic clk,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    // Tracks the strobe in every cycle, restart included, so a level that
    // is already high when a request begins is never seen as a new card.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;

endmodule

// File: rtl/hand21_accum.sv
module hand21_accum
    import hand21_pkg::*;
#(
    parameter int CARD_W     = CARD_BITS,
    parameter int TOTAL_W    = TOTAL_BITS,
    parameter int ACE_CNT_W  = ACE_CNT_BITS,
    parameter int ACE_VALUE  = ACE_CARD,
    parameter int HOLD_MIN   = HOLD_FLOOR,
    parameter int BUST_LIMIT = BUST_CEIL,
    parameter int SOFT_STEP  = ACE_DROP
) (
    input  logic               clk,
    input  logic               rst,
    input  acc_op_e            op,
    input  logic [CARD_W-1:0]  card,
    output logic [TOTAL_W-1:0] total,
    output acc_status_t        status
);
    localparam logic [TOTAL_W-1:0]   HOLD_T  = TOTAL_W'(HOLD_MIN);
    localparam logic [TOTAL_W-1:0]   CEIL_T  = TOTAL_W'(BUST_LIMIT);
    localparam logic [TOTAL_W-1:0]   STEP_T  = TOTAL_W'(SOFT_STEP);
    localparam logic [CARD_W-1:0]    ACE_C   = CARD_W'(ACE_VALUE);
    localparam logic [ACE_CNT_W-1:0] CNT_ONE = ACE_CNT_W'(1);

    logic [TOTAL_W-1:0]   total_q;
    logic [ACE_CNT_W-1:0] aces_q;
    logic [TOTAL_W-1:0]   card_ext;
    logic                 card_ace;

    assign card_ext = TOTAL_W'(card);
    assign card_ace = (card == ACE_C);

    always_ff @(posedge clk) begin
        unique case (op)
            ACC_CLEAR: begin
                total_q <= '0;
                aces_q  <= '0;
            end
            ACC_ADD: begin
                total_q <= total_q + card_ext;
                if (card_ace) begin
                    aces_q <= aces_q + CNT_ONE;
                end
            end
            ACC_SOFTEN: begin
                total_q <= total_q - STEP_T;
                aces_q  <= aces_q - CNT_ONE;
            end
            default: begin
                total_q <= total_q;
                aces_q  <= aces_q;
            end
        endcase
    end

    assign total              = total_q;
    assign status.reach_hold  = (total_q >= HOLD_T);
    assign status.within_ceil = (total_q <= CEIL_T);
    assign status.ace_left    = (aces_q != '0);

    // R4: without an add or soften command the score holds its value
    a_r4_keep_stable: assert property (@(posedge clk) disable iff (rst)
        (op == ACC_KEEP) |=> $stable(total_q));

    // R4: an accepted card moves the score by its own value
    a_r4_add_step: assert property (@(posedge clk) disable iff (rst)
        (op == ACC_ADD) |=> (total_q == $past(total_q) + $past(card_ext)));

    // R8: softening removes the step and one counted high card
    a_r8_soften_step: assert property (@(posedge clk) disable iff (rst)
        (op == ACC_SOFTEN) |=> ((total_q == $past(total_q) - STEP_T) &&
                                (aces_q == $past(aces_q) - CNT_ONE)));

    // R8: only a high card that is still counted can be softened
    a_r8_soften_has_ace: assert property (@(posedge clk) disable iff (rst)
        (op == ACC_SOFTEN) |-> (aces_q != '0));

endmodule

// File: rtl/hand21_ctrl.sv
module hand21_ctrl
    import hand21_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rise,
    input  logic        strobe_lvl,
    input  acc_status_t st,
    output acc_op_e     op,
    output play_flags_t flags
);
    play_state_e state_q;
    play_state_e state_d;
    acc_op_e     op_d;

    always_comb begin
        state_d = state_q;
        op_d    = ACC_KEEP;
        unique case (state_q)
            PS_START: state_d = PS_ASK;
            PS_ASK: begin
                if (rise) begin
                    state_d = PS_TAKE;
                    op_d    = ACC_ADD;
                end
            end
            PS_TAKE: begin
                if (!strobe_lvl) begin
                    state_d = PS_CHK_LOW;
                end
            end
            PS_CHK_LOW: state_d = st.reach_hold ? PS_CHK_HIGH : PS_ASK;
            PS_CHK_HIGH: begin
                if (st.within_ceil) begin
                    state_d = PS_HOLD;
                end else if (st.ace_left) begin
                    state_d = PS_CHK_LOW;
                    op_d    = ACC_SOFTEN;
                end else begin
                    state_d = PS_BUST;
                end
            end
            PS_HOLD: state_d = PS_HOLD;
            PS_BUST: state_d = PS_BUST;
            default: state_d = PS_START;
        endcase
        if (rst) begin
            op_d = ACC_CLEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_START;
        end else begin
            state_q <= state_d;
        end
    end

    assign op    = op_d;
    assign flags = flags_of_state(state_q);

    // R2: the start cycle lasts one clock and leads into a request
    a_r2_start_to_ask: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_START) |=> (state_q == PS_ASK));

    // R3: a request is held until a strobe rise is seen
    a_r3_ask_waits: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PS_ASK) && !rise) |=> (state_q == PS_ASK));

    // R5: an accepted card is not evaluated while the strobe is high
    a_r5_take_waits: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PS_TAKE) && strobe_lvl) |=> (state_q == PS_TAKE));

    // R7: a score within the ceiling stands before any softening
    a_r7_priority: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PS_CHK_HIGH) && st.within_ceil) |=> (state_q == PS_HOLD));

    // R10: outcomes are terminal until restart
    a_r10_hold_stays: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_HOLD) |=> (state_q == PS_HOLD));
    a_r10_bust_stays: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_BUST) |=> (state_q == PS_BUST));

endmodule

// File: rtl/hand21_player.sv
module hand21_player
    import hand21_pkg::*;
#(
    parameter int CARD_W     = CARD_BITS,
    parameter int TOTAL_W    = TOTAL_BITS,
    parameter int ACE_CNT_W  = ACE_CNT_BITS,
    parameter int ACE_VALUE  = ACE_CARD,
    parameter int HOLD_MIN   = HOLD_FLOOR,
    parameter int BUST_LIMIT = BUST_CEIL,
    parameter int SOFT_STEP  = ACE_DROP
) (
    input  logic               clk,
    input  logic               new_game,
    input  logic               card_strobe,
    input  logic [CARD_W-1:0]  card_value,
    output logic               want_card,
    output logic               hold_flag,
    output logic               bust_flag,
    output logic [TOTAL_W-1:0] score
);
    localparam logic [TOTAL_W-1:0] HOLD_LO = TOTAL_W'(HOLD_MIN);
    localparam logic [TOTAL_W-1:0] HOLD_HI = TOTAL_W'(BUST_LIMIT);

    logic        strobe_rise;
    acc_op_e     acc_op;
    acc_status_t acc_st;
    play_flags_t flags;

    hand21_edge u_edge (
        .clk    (clk),
        .strobe (card_strobe),
        .rise   (strobe_rise)
    );

    hand21_ctrl u_ctrl (
        .clk        (clk),
        .rst        (new_game),
        .rise       (strobe_rise),
        .strobe_lvl (card_strobe),
        .st         (acc_st),
        .op         (acc_op),
        .flags      (flags)
    );

    hand21_accum #(
        .CARD_W     (CARD_W),
        .TOTAL_W    (TOTAL_W),
        .ACE_CNT_W  (ACE_CNT_W),
        .ACE_VALUE  (ACE_VALUE),
        .HOLD_MIN   (HOLD_MIN),
        .BUST_LIMIT (BUST_LIMIT),
        .SOFT_STEP  (SOFT_STEP)
    ) u_accum (
        .clk    (clk),
        .rst    (new_game),
        .op     (acc_op),
        .card   (card_value),
        .total  (score),
        .status (acc_st)
    );

    assign want_card = flags.want;
    assign hold_flag = flags.hold;
    assign bust_flag = flags.bust;

    // R1: a restart clears the score and all flags by the next cycle
    a_r1_restart_clears: assert property (@(posedge clk)
        new_game |=> ((score == '0) && !want_card && !hold_flag && !bust_flag));

    // R11: the three flags never overlap
    a_r11_one_flag: assert property (@(posedge clk) disable iff (new_game)
        $onehot0({want_card, hold_flag, bust_flag}));

    // R7: a standing hand shows a score in the stand window
    a_r7_hold_window: assert property (@(posedge clk) disable iff (new_game)
        hold_flag |-> ((score >= HOLD_LO) && (score <= HOLD_HI)));

    // R9: a bust hand shows a score above the ceiling
    a_r9_bust_above: assert property (@(posedge clk) disable iff (new_game)
        bust_flag |-> (score > HOLD_HI));

endmodule

// File: tb/sim_hand21_player.sv
`timescale 1ns/1ps
module sim_hand21_player;

    logic       clk = 1'b0;
    logic       new_game = 1'b1;
    logic       card_strobe = 1'b0;
    logic [3:0] card_value = 4'd0;
    logic       want_card;
    logic       hold_flag;
    logic       bust_flag;
    logic [4:0] score;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hand21_player u0 (
        .clk         (clk),
        .new_game    (new_game),
        .card_strobe (card_strobe),
        .card_value  (card_value),
        .want_card   (want_card),
        .hold_flag   (hold_flag),
        .bust_flag   (bust_flag),
        .score       (score)
    );

    typedef struct packed {
        logic [31:0] cards;   // first card in the low nibble
        logic        hold;    // 1: stands, 0: bust
        logic [4:0]  total;
        logic [3:0]  used;
    } hand_vec_t;

    localparam int NVEC = 12;
    localparam hand_vec_t HANDS [NVEC] = '{
        '{32'h0000_007A, 1'b1, 5'd17, 4'd2},  // 10,7 stands at floor
        '{32'h0000_056A, 1'b1, 5'd21, 4'd3},  // 16 asks again, 21 stands
        '{32'h0000_086A, 1'b0, 5'd24, 4'd3},  // no high card: bust
        '{32'h0000_0B5B, 1'b1, 5'd17, 4'd3},  // two high cards, one softened
        '{32'h0000_09BB, 1'b1, 5'd21, 4'd3},  // 22 softened to 12, then 21
        '{32'h000A_ABBB, 1'b0, 5'd23, 4'd5},  // three high cards, each softened once
        '{32'h0003_5432, 1'b1, 5'd17, 4'd5},  // small cards
        '{32'h0000_0B6A, 1'b1, 5'd17, 4'd3},  // 27 softened to 17
        '{32'h0000_0A79, 1'b0, 5'd26, 4'd3},  // largest plain total
        '{32'h0000_006B, 1'b1, 5'd17, 4'd2},  // stand beats softening
        '{32'h0000_00AB, 1'b1, 5'd21, 4'd2},  // 21 with high card kept
        '{32'h0000_AA5B, 1'b0, 5'd26, 4'd4}   // softened once, then bust
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk);
        new_game = 1'b1;
        repeat (2) @(negedge clk);
        new_game = 1'b0;
    endtask

    task automatic wait_turn();
        int n = 0;
        @(negedge clk);
        while (!(want_card || hold_flag || bust_flag) && n < 60) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic deal(input logic [3:0] c);
        card_value  = c;
        card_strobe = 1'b1;
        @(negedge clk);
        card_strobe = 1'b0;
    endtask

    task automatic play_hand(input logic [31:0] cards, output int used);
        used = 0;
        for (int i = 0; i < 8; i++) begin
            wait_turn();
            if (hold_flag || bust_flag) break;
            deal(cards[i*4 +: 4]);
            used++;
        end
        if (!(hold_flag || bust_flag)) wait_turn();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int used;
        logic [4:0] keep;

        // R1/R2: state right after restart, then the first request
        restart();
        check(score == 0, "R1", "score after restart", score, 0);
        check({want_card, hold_flag, bust_flag} == 3'b000, "R1", "flags after restart",
              {want_card, hold_flag, bust_flag}, 0);
        check(want_card == 1'b0, "R2", "start cycle want", want_card, 0);
        @(negedge clk);
        check(want_card == 1'b1, "R2", "request after start", want_card, 1);

        // table of whole hands: R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            restart();
            play_hand(HANDS[v].cards, used);
            check(hold_flag == HANDS[v].hold, "R7", $sformatf("hand %0d stand", v),
                  hold_flag, HANDS[v].hold);
            check(bust_flag == !HANDS[v].hold, "R9", $sformatf("hand %0d bust", v),
                  bust_flag, !HANDS[v].hold);
            check(score == HANDS[v].total, "R8", $sformatf("hand %0d score", v),
                  score, HANDS[v].total);
            check(used == int'(HANDS[v].used), "R6", $sformatf("hand %0d cards", v),
                  used, HANDS[v].used);
            check(want_card == 1'b0, "R11", $sformatf("hand %0d want", v), want_card, 0);
        end

        // R10: after standing, strobes and values change nothing
        restart();
        play_hand(32'h0000_007A, used);
        keep = score;
        for (int k = 0; k < 3; k++) begin
            deal(4'd10);
            @(negedge clk);
        end
        check(hold_flag == 1'b1, "R10", "stand kept", hold_flag, 1);
        check(score == keep, "R10", "score kept after stand", score, keep);
        check(want_card == 1'b0, "R10", "no request after stand", want_card, 0);

        // R10: after bust, likewise
        restart();
        play_hand(32'h0000_086A, used);
        keep = score;
        for (int k = 0; k < 3; k++) begin
            deal(4'd2);
            @(negedge clk);
        end
        check(bust_flag == 1'b1, "R10", "bust kept", bust_flag, 1);
        check(score == keep, "R10", "score kept after bust", score, keep);

        // R1: restart in the middle of a hand
        restart();
        wait_turn();
        deal(4'd9);
        repeat (3) @(negedge clk);
        check(score == 9, "R4", "mid-hand score", score, 9);
        restart();
        check(score == 0, "R1", "mid-hand restart score", score, 0);
        check(want_card == 1'b0, "R1", "mid-hand restart want", want_card, 0);

        // R3: strobe already high through the restart is not a card
        @(negedge clk);
        card_strobe = 1'b1;
        card_value  = 4'd7;
        new_game    = 1'b1;
        repeat (2) @(negedge clk);
        new_game = 1'b0;
        repeat (6) @(negedge clk);
        check(want_card == 1'b1, "R3", "held strobe ignored want", want_card, 1);
        check(score == 0, "R3", "held strobe ignored score", score, 0);
        card_strobe = 1'b0;
        @(negedge clk);
        check(score == 0, "R3", "falling strobe ignored", score, 0);

        // R4/R5: card held on the strobe for many cycles is added once
        card_value  = 4'd5;
        card_strobe = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(score == 5, "R4", "added once while strobe high", score, 5);
            check({want_card, hold_flag, bust_flag} == 3'b000, "R5",
                  "no flag while strobe high", {want_card, hold_flag, bust_flag}, 0);
        end
        card_strobe = 1'b0;
        repeat (2) @(negedge clk);
        check(want_card == 1'b1, "R6", "low score asks again", want_card, 1);
        check(score == 5, "R6", "score after re-ask", score, 5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule